// File: doc/BRIEF.md
# DDR Command Decoder with Mode Registers

This block sits on the memory side of a DDR command bus. It takes chip select, the three active-low command strobes, the bank-address bits and the address bus on every rising clock edge, and turns each sample into one command class. The result is held on registered outputs for one clock. READ and WRITE also report their bank and whether the row should close by itself after the burst. PRECHARGE reports whether it covers one bank or every bank.

The block holds the two mode registers that a MODE REGISTER SET can load. It decodes their fields into burst length, burst ordering, CAS latency (in half clocks), DLL enable, output drive strength and a one-clock DLL-reset pulse. It also keeps a bitmap of open banks. With it, the block flags a mode register load that arrives while a row is open, and a stored burst-length or latency code that has no legal meaning.

A small two-state machine, `DLLR_IDLE` and `DLLR_PULSE`, handles the self-clearing DLL-reset bit. It moves from `DLLR_IDLE` to `DLLR_PULSE` on a base register load with address bit 8 set. It stays in `DLLR_PULSE` if another such load arrives. On any other cycle it returns to `DLLR_IDLE` and clears the stored bit.

Top module: `ddr_cmd_decoder`

## Requirements
- R1: The strobes are sampled only at the rising edge, and the class shows on `cmd` from that edge until the next one. Active-low {ras_n,cas_n,we_n} decode as 111 NOP=1, 011 ACTIVE=2, 101 READ=3, 100 WRITE=4, 010 PRECHARGE=5, 001 AUTO REFRESH=6, 000 MODE REGISTER SET=7. The code 110 is reported as NOP=1.
- R2: With cs_n high at the edge, `cmd` is DESELECT=0. Neither the mode registers nor the open-bank bitmap change.
- R3: On READ or WRITE, `cmd_bank` equals `ba` and `auto_pre` equals address bit 10. `auto_pre` is 0 for every other class.
- R4: On PRECHARGE, `pre_all` equals address bit 10. `pre_all` is 0 for every other class.
- R5: `open_banks` bit b is set by ACTIVE to bank b. It is cleared by PRECHARGE to bank b with bit 10 low, or by any PRECHARGE with bit 10 high. The change is visible after the same edge.
- R6: A MODE REGISTER SET with ba=0 loads the base register. Bits 2:0 give `burst_len`: 001→2, 010→4, 011→8. Bit 3 gives `burst_interleave`. Bits 6:4 give `cas_x2` in half clocks: 010→4, 110→5, 011→6. Bits 12:7 appear on `op_mode`.
- R7: Any other burst-length or latency code drives that field to 0 and raises `cfg_reserved_err`.
- R8: A MODE REGISTER SET with ba=1 loads the extended register. `dll_enable` is the inverse of bit 0, and `drive_weak` is bit 1.
- R9: A MODE REGISTER SET with ba=2 or ba=3 changes neither register.
- R10: A base load with bit 8 set raises `dll_reset` and `op_mode[1]` for exactly the next clock. Both then clear by themselves.
- R11: `mrs_illegal` is 1 for the clock after a MODE REGISTER SET that arrives while any bit of `open_banks` is set, and 0 otherwise. The load itself still takes effect.
- R12: After reset, `cmd`=0, `open_banks`=0, `burst_len`=2, `cas_x2`=4, `burst_interleave`=0, `dll_enable`=1, `drive_weak`=0, `dll_reset`=0 and `cfg_reserved_err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| addr | input | 13 | Address / mode op-code |
| cmd | output | 3 | Decoded command class |
| cmd_bank | output | 2 | Bank of the last command |
| auto_pre | output | 1 | READ/WRITE asked for auto-precharge |
| pre_all | output | 1 | PRECHARGE covers all banks |
| open_banks | output | 4 | Open-row bitmap |
| mrs_illegal | output | 1 | Mode load with a bank open |
| burst_len | output | 4 | Burst length in beats, 0 if reserved |
| burst_interleave | output | 1 | Interleaved burst order |
| cas_x2 | output | 3 | CAS latency in half clocks, 0 if reserved |
| op_mode | output | 6 | Base register bits 12:7 |
| dll_enable | output | 1 | DLL enabled |
| drive_weak | output | 1 | Reduced output drive |
| dll_reset | output | 1 | One-clock DLL reset pulse |
| cfg_reserved_err | output | 1 | Stored field uses a reserved code |

## Verification
Every result except the DLL-reset clear is due right after the rising edge that samples the command. This covers the class, the bank, the precharge scope, the bitmap, the register fields and the illegal-load flag. The DLL-reset clear comes one edge later. The bench drives pins on the falling edge, waits for the next rising edge, then reads the outputs a step later. For the DLL-reset clear it issues one NOP and reads again. It sweeps all sixteen strobe patterns, all eight burst-length codes and all eight latency codes.

// File: rtl/ddr_cmd_pkg.sv
package ddr_cmd_pkg;

    typedef enum logic [2:0] {
        CMD_DESEL = 3'd0,
        CMD_NOP   = 3'd1,
        CMD_ACT   = 3'd2,
        CMD_RD    = 3'd3,
        CMD_WR    = 3'd4,
        CMD_PRE   = 3'd5,
        CMD_REF   = 3'd6,
        CMD_MRS   = 3'd7
    } cmd_kind_t;

    typedef enum logic {
        DLLR_IDLE  = 1'b0,
        DLLR_PULSE = 1'b1
    } dllr_state_t;

endpackage

// File: rtl/ddr_cmd_classify.sv
module ddr_cmd_classify
    import ddr_cmd_pkg::*;
(
    input  logic      cs_n,
    input  logic      ras_n,
    input  logic      cas_n,
    input  logic      we_n,
    output cmd_kind_t kind
);
    always_comb begin
        if (cs_n) begin
            kind = CMD_DESEL;
        end else begin
            unique case ({ras_n, cas_n, we_n})
                3'b011:  kind = CMD_ACT;
                3'b101:  kind = CMD_RD;
                3'b100:  kind = CMD_WR;
                3'b010:  kind = CMD_PRE;
                3'b001:  kind = CMD_REF;
                3'b000:  kind = CMD_MRS;
                default: kind = CMD_NOP;
            endcase
        end
    end
endmodule

// File: rtl/ddr_bank_tracker.sv
module ddr_bank_tracker #(
    parameter int BANKS = 4,
    localparam int BA_W = $clog2(BANKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act,
    input  logic             pre,
    input  logic             pre_all,
    input  logic [BA_W-1:0]  ba,
    output logic [BANKS-1:0] open_q
);
    for (genvar g = 0; g < BANKS; g++) begin : g_bank
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                open_q[g] <= 1'b0;
            end else if (act && ba == BA_W'(g)) begin
                open_q[g] <= 1'b1;
            end else if (pre && (pre_all || ba == BA_W'(g))) begin
                open_q[g] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/ddr_mode_regs.sv
module ddr_mode_regs
    import ddr_cmd_pkg::*;
#(
    parameter int ADDR_W     = 13,
    parameter int DLLRST_BIT = 8,
    parameter logic [ADDR_W-1:0] BASE_RST = ADDR_W'(12'h021),
    localparam int OP_W = ADDR_W - 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_base,
    input  logic              load_ext,
    input  logic [ADDR_W-1:0] addr,
    output logic [3:0]        burst_len,
    output logic              burst_interleave,
    output logic [2:0]        cas_x2,
    output logic [OP_W-1:0]   op_mode,
    output logic              dll_enable,
    output logic              drive_weak,
    output logic              dll_reset,
    output logic              cfg_reserved_err
);
    logic [ADDR_W-1:0] base_q;
    logic [1:0]        ext_q;
    dllr_state_t       state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DLLR_IDLE:  if (load_base && addr[DLLRST_BIT]) state_d = DLLR_PULSE;
            DLLR_PULSE: if (!(load_base && addr[DLLRST_BIT])) state_d = DLLR_IDLE;
            default:    state_d = DLLR_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= DLLR_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= BASE_RST;
            ext_q  <= 2'b00;
        end else begin
            if (load_base) begin
                base_q <= addr;
            end else if (state_q == DLLR_PULSE) begin
                base_q[DLLRST_BIT] <= 1'b0;
            end
            if (load_ext) ext_q <= addr[1:0];
        end
    end

    always_comb begin
        unique case (base_q[2:0])
            3'b001:  burst_len = 4'd2;
            3'b010:  burst_len = 4'd4;
            3'b011:  burst_len = 4'd8;
            default: burst_len = 4'd0;
        endcase
        unique case (base_q[6:4])
            3'b010:  cas_x2 = 3'd4;
            3'b110:  cas_x2 = 3'd5;
            3'b011:  cas_x2 = 3'd6;
            default: cas_x2 = 3'd0;
        endcase
    end

    assign burst_interleave = base_q[3];
    assign op_mode          = base_q[ADDR_W-1:7];
    assign dll_enable       = ~ext_q[0];
    assign drive_weak       = ext_q[1];
    assign dll_reset        = (state_q == DLLR_PULSE);
    assign cfg_reserved_err = (burst_len == 4'd0) || (cas_x2 == 3'd0);
endmodule

// File: rtl/ddr_cmd_decoder.sv
module ddr_cmd_decoder
    import ddr_cmd_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int BANKS  = 4,
    parameter int AP_BIT = 10,
    localparam int BA_W  = $clog2(BANKS),
    localparam int OP_W  = ADDR_W - 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [BA_W-1:0]   ba,
    input  logic [ADDR_W-1:0] addr,
    output logic [2:0]        cmd,
    output logic [BA_W-1:0]   cmd_bank,
    output logic              auto_pre,
    output logic              pre_all,
    output logic [BANKS-1:0]  open_banks,
    output logic              mrs_illegal,
    output logic [3:0]        burst_len,
    output logic              burst_interleave,
    output logic [2:0]        cas_x2,
    output logic [OP_W-1:0]   op_mode,
    output logic              dll_enable,
    output logic              drive_weak,
    output logic              dll_reset,
    output logic              cfg_reserved_err
);
    cmd_kind_t kind_c, kind_q;
    logic      col_cmd, is_pre, load_base, load_ext;

    ddr_cmd_classify u_cls (
        .cs_n (cs_n), .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n), .kind (kind_c)
    );

    assign col_cmd   = (kind_c == CMD_RD) || (kind_c == CMD_WR);
    assign is_pre    = (kind_c == CMD_PRE);
    assign load_base = (kind_c == CMD_MRS) && (ba == BA_W'(0));
    assign load_ext  = (kind_c == CMD_MRS) && (ba == BA_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q      <= CMD_DESEL;
            cmd_bank    <= '0;
            auto_pre    <= 1'b0;
            pre_all     <= 1'b0;
            mrs_illegal <= 1'b0;
        end else begin
            kind_q      <= kind_c;
            cmd_bank    <= ba;
            auto_pre    <= col_cmd && addr[AP_BIT];
            pre_all     <= is_pre && addr[AP_BIT];
            mrs_illegal <= (kind_c == CMD_MRS) && (|open_banks);
        end
    end

    assign cmd = kind_q;

    ddr_bank_tracker #(.BANKS(BANKS)) u_banks (
        .clk     (clk),
        .rst_n   (rst_n),
        .act     (kind_c == CMD_ACT),
        .pre     (is_pre),
        .pre_all (addr[AP_BIT]),
        .ba      (ba),
        .open_q  (open_banks)
    );

    ddr_mode_regs #(.ADDR_W(ADDR_W)) u_mr (
        .clk              (clk),
        .rst_n            (rst_n),
        .load_base        (load_base),
        .load_ext         (load_ext),
        .addr             (addr),
        .burst_len        (burst_len),
        .burst_interleave (burst_interleave),
        .cas_x2           (cas_x2),
        .op_mode          (op_mode),
        .dll_enable       (dll_enable),
        .drive_weak       (drive_weak),
        .dll_reset        (dll_reset),
        .cfg_reserved_err (cfg_reserved_err)
    );
endmodule

// File: rtl/ddr_cmd_decoder_chk.sv
module ddr_cmd_decoder_chk #(
    parameter int ADDR_W = 13,
    parameter int BANKS  = 4,
    localparam int BA_W  = $clog2(BANKS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [BA_W-1:0]   ba,
    input logic [ADDR_W-1:0] addr,
    input logic [2:0]        cmd,
    input logic              auto_pre,
    input logic              pre_all,
    input logic [BANKS-1:0]  open_banks,
    input logic              mrs_illegal,
    input logic              dll_reset
);
    logic pin_act, pin_mrs, pin_base_rst;
    assign pin_act      = !cs_n && !ras_n && cas_n && we_n;
    assign pin_mrs      = !cs_n && !ras_n && !cas_n && !we_n;
    assign pin_base_rst = pin_mrs && (ba == BA_W'(0)) && addr[8];

    // R2
    desel_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (cmd == 3'd0));

    // R2
    desel_banks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> $stable(open_banks));

    // R5
    act_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pin_act |=> open_banks[$past(ba)]);

    // R4
    pre_all_cls_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pre_all |-> (cmd == 3'd5));

    // R3
    auto_pre_cls_chk: assert property (@(posedge clk) disable iff (!rst_n)
        auto_pre |-> (cmd == 3'd3 || cmd == 3'd4));

    // R11
    mrs_illegal_cls_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mrs_illegal |-> (cmd == 3'd7));

    // R10
    dll_reset_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dll_reset && !pin_base_rst) |=> !dll_reset);

    // R10
    dll_reset_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pin_base_rst |=> dll_reset);
endmodule

bind ddr_cmd_decoder ddr_cmd_decoder_chk #(.ADDR_W(ADDR_W), .BANKS(BANKS)) u_chk (.*);

// File: tb/test_ddr_cmd_decoder.sv
`timescale 1ns/1ps
module test_ddr_cmd_decoder;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0]  ba = 2'd0;
    logic [12:0] addr = 13'd0;
    logic [2:0]  cmd;
    logic [1:0]  cmd_bank;
    logic        auto_pre, pre_all, mrs_illegal;
    logic [3:0]  open_banks;
    logic [3:0]  burst_len;
    logic        burst_interleave;
    logic [2:0]  cas_x2;
    logic [5:0]  op_mode;
    logic        dll_enable, drive_weak, dll_reset, cfg_reserved_err;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #4 clk = ~clk;

    ddr_cmd_decoder i_ddr_cmd_decoder (
        .clk (clk), .rst_n (rst_n), .cs_n (cs_n), .ras_n (ras_n), .cas_n (cas_n),
        .we_n (we_n), .ba (ba), .addr (addr), .cmd (cmd), .cmd_bank (cmd_bank),
        .auto_pre (auto_pre), .pre_all (pre_all), .open_banks (open_banks),
        .mrs_illegal (mrs_illegal), .burst_len (burst_len),
        .burst_interleave (burst_interleave), .cas_x2 (cas_x2), .op_mode (op_mode),
        .dll_enable (dll_enable), .drive_weak (drive_weak), .dll_reset (dll_reset),
        .cfg_reserved_err (cfg_reserved_err)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // drive at falling edge, sample one step after the capturing rising edge
    task automatic issue(input bit c, input bit [2:0] rcw, input bit [1:0] b, input bit [12:0] a);
        @(negedge clk);
        cs_n = c; {ras_n, cas_n, we_n} = rcw; ba = b; addr = a;
        @(posedge clk);
        #1;
    endtask

    function automatic int exp_cmd(input bit c, input bit [2:0] rcw);
        if (c) return 0;
        case (rcw)
            3'b011: return 2;
            3'b101: return 3;
            3'b100: return 4;
            3'b010: return 5;
            3'b001: return 6;
            3'b000: return 7;
            default: return 1;
        endcase
    endfunction

    function automatic int exp_bl(input int code);
        return (code >= 1 && code <= 3) ? (1 << code) : 0;
    endfunction

    function automatic int exp_cl(input int code);
        if (code == 2) return 4;
        if (code == 6) return 5;
        if (code == 3) return 6;
        return 0;
    endfunction

    localparam bit [2:0] NOP = 3'b111, ACT = 3'b011, RD = 3'b101, WR = 3'b100,
                         PRE = 3'b010, MRS = 3'b000;

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R12 reset state
        chk("R12 cmd", cmd, 0);
        chk("R12 open", open_banks, 0);
        chk("R12 bl", burst_len, 2);
        chk("R12 cl", cas_x2, 4);
        chk("R12 bt", burst_interleave, 0);
        chk("R12 dll_en", dll_enable, 1);
        chk("R12 drv", drive_weak, 0);
        chk("R12 dll_rst", dll_reset, 0);
        chk("R12 err", cfg_reserved_err, 0);

        // R1 R2 sweep of every strobe pattern (MRS reloads the default value)
        for (int p = 0; p < 16; p++) begin
            issue(p[3], p[2:0], 2'd0, 13'h021);
            chk("R1 cmd class", cmd, exp_cmd(p[3], p[2:0]));
        end
        issue(1'b0, PRE, 2'd0, 13'h400);
        chk("R5 pre all clears", open_banks, 0);

        // R5 ACTIVE per bank
        for (int b = 0; b < 4; b++) begin
            issue(1'b0, ACT, 2'(b), 13'h000);
            chk("R5 act opens", open_banks, (1 << (b + 1)) - 1);
        end
        // R11 load with banks open; load still applies
        issue(1'b0, MRS, 2'd0, 13'h022);
        chk("R11 illegal", mrs_illegal, 1);
        chk("R11 load applied", burst_len, 4);
        // R4 R5 single-bank precharge
        issue(1'b0, PRE, 2'd2, 13'h000);
        chk("R4 single", pre_all, 0);
        chk("R5 single clear", open_banks, 4'b1011);
        // R2 deselect with PRE-all pattern leaves bitmap
        issue(1'b1, PRE, 2'd0, 13'h400);
        chk("R2 desel cmd", cmd, 0);
        chk("R2 desel banks", open_banks, 4'b1011);
        chk("R4 desel no pre_all", pre_all, 0);
        issue(1'b1, MRS, 2'd0, 13'h023);
        chk("R2 desel mrs", burst_len, 4);
        // R3 read/write auto precharge
        issue(1'b0, RD, 2'd3, 13'h400);
        chk("R3 rd ap", auto_pre, 1);
        chk("R3 rd bank", cmd_bank, 3);
        issue(1'b0, WR, 2'd1, 13'h000);
        chk("R3 wr no ap", auto_pre, 0);
        chk("R3 wr bank", cmd_bank, 1);
        issue(1'b0, ACT, 2'd1, 13'h400);
        chk("R3 act no ap", auto_pre, 0);
        // R4 precharge all
        issue(1'b0, PRE, 2'd1, 13'h400);
        chk("R4 all", pre_all, 1);
        chk("R5 all clear", open_banks, 0);
        issue(1'b0, MRS, 2'd0, 13'h021);
        chk("R11 legal", mrs_illegal, 0);

        // R6 R7 burst-length sweep
        for (int c = 0; c < 8; c++) begin
            issue(1'b0, MRS, 2'd0, 13'(12'h020 | c));
            chk("R6 bl", burst_len, exp_bl(c));
            chk("R7 bl err", cfg_reserved_err, exp_bl(c) == 0 ? 1 : 0);
        end
        // R6 R7 latency sweep
        for (int c = 0; c < 8; c++) begin
            issue(1'b0, MRS, 2'd0, 13'((c << 4) | 1));
            chk("R6 cl", cas_x2, exp_cl(c));
            chk("R7 cl err", cfg_reserved_err, exp_cl(c) == 0 ? 1 : 0);
        end
        // R6 burst type and op mode
        issue(1'b0, MRS, 2'd0, 13'h1E2B);
        chk("R6 bt", burst_interleave, 1);
        chk("R6 op", op_mode, 6'h3C);
        chk("R6 bl8", burst_len, 8);

        // R8 extended register
        issue(1'b0, MRS, 2'd1, 13'h003);
        chk("R8 dll off", dll_enable, 0);
        chk("R8 weak", drive_weak, 1);
        chk("R8 base kept", burst_len, 8);
        issue(1'b0, MRS, 2'd1, 13'h000);
        chk("R8 dll on", dll_enable, 1);

        // R9 reserved bank selects
        issue(1'b0, MRS, 2'd2, 13'h001);
        chk("R9 ba2 base", burst_len, 8);
        issue(1'b0, MRS, 2'd3, 13'h003);
        chk("R9 ba3 ext", dll_enable, 1);
        chk("R9 ba3 base", burst_len, 8);

        // R10 DLL reset pulse and self clear
        issue(1'b0, MRS, 2'd0, 13'h121);
        chk("R10 pulse", dll_reset, 1);
        chk("R10 op bit", op_mode[1], 1);
        issue(1'b0, NOP, 2'd0, 13'h000);
        chk("R10 cleared", dll_reset, 0);
        chk("R10 op bit cleared", op_mode[1], 0);
        chk("R10 fields kept", burst_len, 2);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule